// File: doc/BRIEF.md
# Three-Channel Serial Register Front End

This block is the bus-facing register file for a group of serial channels. A host reads and writes single bytes or halfwords at byte offsets, and the block decodes each access to one channel's control, interrupt-mode, transmit, receive or status register. The last channel also has an 8-bit timer register. Every access is checked against that register's allowed sizes, its direction and its read-only bits. An access that fails a check is refused and flagged on an error strobe. Serial timing and shifting are done elsewhere: that logic hands a received byte to this block with a valid strobe and takes each transmitted byte from a data output and a send strobe.

Each channel keeps a receive-ready flag. A byte arriving from the line sets the flag. A byte read of the receive buffer clears it. Bus accesses take one cycle: the request is sampled on a clock edge, and the read data and error strobe are registered and show in the cycle after the request.

Top module: `sreg_front`

## Requirements
- R1: After reset every control, interrupt-mode, transmit, receive, timer and status register reads as zero, and the tx_send, rx_event and bus_err outputs are low.
- R2: Channel n owns offsets 0x10*n to 0x10*n+0xF. Within that window the registers sit at these offsets: control at 0x0, interrupt mode at 0x4, transmit buffer at 0x8, receive buffer at 0x9 and status at 0xC. Any other offset, and any channel number past the last channel, is illegal.
- R3: The control register is 16 bits wide and accepts only halfword accesses. On the last channel, a write that has any bit of 0x0C04 set is illegal. The other channels accept those bits.
- R4: The interrupt-mode register is 8 bits wide and accepts only byte accesses. A write is illegal if it sets any bit of 0xCA on the last channel, or any bit of 0x4A on the other channels.
- R5: When rx_valid[n] is high at a clock edge, channel n loads rx_byte into its receive buffer, sets status bit 4 (value 0x0010), and raises rx_event[n] for exactly the one following cycle.
- R6: A byte read of the receive buffer returns the stored byte and clears the ready flag. A byte that arrives while the flag is still set overwrites the buffer and leaves the flag set. If a byte arrives in the same cycle as a receive-buffer read, the read returns the old byte, and the new byte is stored with the flag still set.
- R7: A status register can be read as a byte on every channel. It can be read as a halfword only on channels other than the last. Any write to a status register or a receive buffer is illegal.
- R8: A byte write to a transmit buffer stores the value and drives it on that channel's tx_byte lane. It also pulses that channel's tx_send for one cycle, and the stored value reads back as a byte.
- R9: The last channel's timer register sits at its window offset 0xD (0x2D with three channels). It is read and written only as a byte.
- R10: An illegal access raises bus_err for one cycle and changes no register. Its read data is zero.
- R11: Read data appears on bus_rdata in the cycle after the request. A byte read returns the byte in bits 7:0, and a halfword read returns the register in little-endian order, with the byte at the lower address in bits 7:0. After a write or an idle cycle, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_addr | input | ADDR_W (6) | Byte offset into the register block |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_half | input | 1 | 1 for a halfword access, 0 for a byte access |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | One-cycle strobe marking a refused access |
| rx_byte | input | 8*NUM_CH | Received byte for each channel, channel n in lane n |
| rx_valid | input | NUM_CH | Per-channel strobe marking a received byte |
| tx_byte | output | 8*NUM_CH | Transmit buffer contents for each channel |
| tx_send | output | NUM_CH | Per-channel one-cycle transmit strobe |
| rx_event | output | NUM_CH | Per-channel one-cycle receive pulse |

## Verification
The bench targets the rules that change from one channel to the next. It writes the same control and interrupt-mode values to the last channel and to an ordinary channel. A design that applied one mask to every channel would either refuse a legal write or store a forbidden bit. The bench also reads status and control registers in both sizes, and checks that a refused write leaves the old value in place. For the receive path it covers three cases: a byte that overwrites an unread byte, a read that clears the ready flag, and a byte that arrives in the same cycle as a read. A design that let the read win that race would lose the new byte's ready flag, and one that read after the update would return the wrong byte.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;
   localparam int WIN_W  = 4;

   localparam logic [WIN_W-1:0] OFS_CTL   = 4'h0;
   localparam logic [WIN_W-1:0] OFS_IMODE = 4'h4;
   localparam logic [WIN_W-1:0] OFS_TXB   = 4'h8;
   localparam logic [WIN_W-1:0] OFS_RXB   = 4'h9;
   localparam logic [WIN_W-1:0] OFS_STAT  = 4'hC;
   localparam logic [WIN_W-1:0] OFS_TIM   = 4'hD;

   localparam int RDY_BIT = 4;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_CTL,
      REG_IMODE,
      REG_TXB,
      REG_RXB,
      REG_STAT,
      REG_TIM
   } reg_e;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
   import sreg_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter logic [HALF_W-1:0] CTL_RO_LAST   = 16'h0C04,
   parameter logic [BYTE_W-1:0] IMODE_RO_LAST = 8'hCA,
   parameter logic [BYTE_W-1:0] IMODE_RO_STD  = 8'h4A,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = WIN_W + CH_W
) (
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              half,
   input  logic [HALF_W-1:0] wdata,
   output logic              ok,
   output logic              bad,
   output logic [CH_W-1:0]   ch,
   output reg_e              kind
);
   logic [WIN_W-1:0]  ofs;
   logic              in_range;
   logic              last;
   logic              legal;
   logic [BYTE_W-1:0] imask;

   always_comb begin
      ch       = addr[ADDR_W-1:WIN_W];
      ofs      = addr[WIN_W-1:0];
      in_range = (ch <= CH_W'(NUM_CH - 1));
      last     = (ch == CH_W'(NUM_CH - 1));
      imask    = last ? IMODE_RO_LAST : IMODE_RO_STD;
      kind     = REG_NONE;
      legal    = 1'b0;
      if (in_range) begin
         case (ofs)
            OFS_CTL: begin
               kind  = REG_CTL;
               legal = half && !(we && last && |(wdata & CTL_RO_LAST));
            end
            OFS_IMODE: begin
               kind  = REG_IMODE;
               legal = !half && !(we && |(wdata[BYTE_W-1:0] & imask));
            end
            OFS_TXB: begin
               kind  = REG_TXB;
               legal = !half;
            end
            OFS_RXB: begin
               kind  = REG_RXB;
               legal = !half && !we;
            end
            OFS_STAT: begin
               kind  = REG_STAT;
               legal = !we && (!half || !last);
            end
            OFS_TIM: begin
               if (last) begin
                  kind  = REG_TIM;
                  legal = !half;
               end
            end
            default: begin
               kind  = REG_NONE;
               legal = 1'b0;
            end
         endcase
      end
      ok  = req && legal;
      bad = req && !legal;
   end
endmodule

// File: rtl/sreg_channel.sv
module sreg_channel
   import sreg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              imode_wr,
   input  logic              txb_wr,
   input  logic              rxb_rd,
   input  logic [HALF_W-1:0] wdata,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [HALF_W-1:0] ctl_q,
   output logic [BYTE_W-1:0] imode_q,
   output logic [BYTE_W-1:0] txb_q,
   output logic [BYTE_W-1:0] rxb_q,
   output logic              rdy_q,
   output logic              tx_send,
   output logic              rx_evt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         imode_q <= '0;
         txb_q   <= '0;
         rxb_q   <= '0;
         rdy_q   <= 1'b0;
         tx_send <= 1'b0;
         rx_evt  <= 1'b0;
      end else begin
         if (ctl_wr)   ctl_q   <= wdata;
         if (imode_wr) imode_q <= wdata[BYTE_W-1:0];
         if (txb_wr)   txb_q   <= wdata[BYTE_W-1:0];
         tx_send <= txb_wr;
         rx_evt  <= rx_valid;
         if (rx_valid) begin
            rxb_q <= rx_byte;
            rdy_q <= 1'b1;
         end else if (rxb_rd) begin
            rdy_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sreg_front.sv
module sreg_front
   import sreg_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter logic [HALF_W-1:0] CTL_RO_LAST   = 16'h0C04,
   parameter logic [BYTE_W-1:0] IMODE_RO_LAST = 8'hCA,
   parameter logic [BYTE_W-1:0] IMODE_RO_STD  = 8'h4A,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = WIN_W + CH_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_req,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_we,
   input  logic                     bus_half,
   input  logic [HALF_W-1:0]        bus_wdata,
   output logic [HALF_W-1:0]        bus_rdata,
   output logic                     bus_err,
   input  logic [BYTE_W*NUM_CH-1:0] rx_byte,
   input  logic [NUM_CH-1:0]        rx_valid,
   output logic [BYTE_W*NUM_CH-1:0] tx_byte,
   output logic [NUM_CH-1:0]        tx_send,
   output logic [NUM_CH-1:0]        rx_event
);
   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_count
         $error("sreg_front: NUM_CH must lie in 1..16");
      end
   endgenerate

   logic            acc_ok;
   logic            acc_bad;
   logic [CH_W-1:0] acc_ch;
   reg_e            acc_kind;

   sreg_decode #(
      .NUM_CH(NUM_CH),
      .CTL_RO_LAST(CTL_RO_LAST),
      .IMODE_RO_LAST(IMODE_RO_LAST),
      .IMODE_RO_STD(IMODE_RO_STD)
   ) u_dec (
      .req(bus_req),
      .addr(bus_addr),
      .we(bus_we),
      .half(bus_half),
      .wdata(bus_wdata),
      .ok(acc_ok),
      .bad(acc_bad),
      .ch(acc_ch),
      .kind(acc_kind)
   );

   logic [HALF_W-1:0] ctl_a   [NUM_CH];
   logic [BYTE_W-1:0] imode_a [NUM_CH];
   logic [BYTE_W-1:0] txb_a   [NUM_CH];
   logic [BYTE_W-1:0] rxb_a   [NUM_CH];
   logic              rdy_a   [NUM_CH];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic hit;
         assign hit = acc_ok && (acc_ch == CH_W'(i));

         sreg_channel u_ch (
            .clk(clk),
            .rst_n(rst_n),
            .ctl_wr(hit && bus_we && acc_kind == REG_CTL),
            .imode_wr(hit && bus_we && acc_kind == REG_IMODE),
            .txb_wr(hit && bus_we && acc_kind == REG_TXB),
            .rxb_rd(hit && !bus_we && acc_kind == REG_RXB),
            .wdata(bus_wdata),
            .rx_valid(rx_valid[i]),
            .rx_byte(rx_byte[i*BYTE_W +: BYTE_W]),
            .ctl_q(ctl_a[i]),
            .imode_q(imode_a[i]),
            .txb_q(txb_a[i]),
            .rxb_q(rxb_a[i]),
            .rdy_q(rdy_a[i]),
            .tx_send(tx_send[i]),
            .rx_evt(rx_event[i])
         );

         assign tx_byte[i*BYTE_W +: BYTE_W] = txb_a[i];
      end
   endgenerate

   logic [BYTE_W-1:0] tim_q;
   always_ff @(posedge clk) begin
      if (!rst_n) tim_q <= '0;
      else if (acc_ok && bus_we && acc_kind == REG_TIM) tim_q <= bus_wdata[BYTE_W-1:0];
   end

   logic [HALF_W-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (acc_ch == CH_W'(i)) begin
            case (acc_kind)
               REG_CTL:   rd_val = ctl_a[i];
               REG_IMODE: rd_val = HALF_W'(imode_a[i]);
               REG_TXB:   rd_val = HALF_W'(txb_a[i]);
               REG_RXB:   rd_val = HALF_W'(rxb_a[i]);
               REG_STAT:  rd_val = HALF_W'(rdy_a[i]) << RDY_BIT;
               REG_TIM:   rd_val = HALF_W'(tim_q);
               default:   rd_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else begin
         bus_rdata <= (acc_ok && !bus_we) ? rd_val : '0;
         bus_err   <= acc_bad;
      end
   end
endmodule

// File: rtl/sreg_front_chk.sv
module sreg_front_chk
   import sreg_pkg::*;
#(
   parameter int NUM_CH = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_req,
   input logic                     bus_we,
   input logic [HALF_W-1:0]        bus_rdata,
   input logic                     bus_err,
   input logic [NUM_CH-1:0]        rx_valid,
   input logic [BYTE_W*NUM_CH-1:0] tx_byte,
   input logic [NUM_CH-1:0]        tx_send,
   input logic [NUM_CH-1:0]        rx_event
);
   a_r10_err_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_req));
   a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == '0));
   a_r11_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |=> (bus_rdata == '0));
   a_r11_idle_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> (bus_rdata == '0));
   a_r8_one_send: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_send));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
         a_r8_send_from_write: assert property (@(posedge clk) disable iff (!rst_n)
            tx_send[i] |-> $past(bus_req && bus_we));
         a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_send[i] |-> $stable(tx_byte[i*BYTE_W +: BYTE_W]));
         a_r5_event_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
            rx_valid[i] |=> rx_event[i]);
         a_r5_event_source: assert property (@(posedge clk) disable iff (!rst_n)
            rx_event[i] |-> $past(rx_valid[i]));
      end
   endgenerate
endmodule

bind sreg_front sreg_front_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .bus_req(bus_req),
   .bus_we(bus_we),
   .bus_rdata(bus_rdata),
   .bus_err(bus_err),
   .rx_valid(rx_valid),
   .tx_byte(tx_byte),
   .tx_send(tx_send),
   .rx_event(rx_event)
);

// File: tb/sreg_front_bench.sv
`timescale 1ns/1ps
module sreg_front_bench;
   localparam int NUM_CH = 3;
   localparam int ADDR_W = 6;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                bus_req = 1'b0;
   logic [ADDR_W-1:0]   bus_addr = '0;
   logic                bus_we = 1'b0;
   logic                bus_half = 1'b0;
   logic [15:0]         bus_wdata = '0;
   logic [15:0]         bus_rdata;
   logic                bus_err;
   logic [8*NUM_CH-1:0] rx_byte = '0;
   logic [NUM_CH-1:0]   rx_valid = '0;
   logic [8*NUM_CH-1:0] tx_byte;
   logic [NUM_CH-1:0]   tx_send;
   logic [NUM_CH-1:0]   rx_event;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   sreg_front u_sreg_front (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_half(bus_half), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_byte(rx_byte),
      .rx_valid(rx_valid), .tx_byte(tx_byte), .tx_send(tx_send),
      .rx_event(rx_event)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic acc(input logic [ADDR_W-1:0] a, input logic w, input logic h,
                      input logic [15:0] d, output logic [15:0] rd, output logic er);
      bus_req = 1'b1; bus_addr = a; bus_we = w; bus_half = h; bus_wdata = d;
      @(negedge clk);
      rd = bus_rdata; er = bus_err;
      bus_req = 1'b0; bus_we = 1'b0; bus_half = 1'b0; bus_wdata = '0;
   endtask

   task automatic push(input int ch, input logic [7:0] b, output logic [NUM_CH-1:0] ev);
      rx_byte[ch*8 +: 8] = b; rx_valid[ch] = 1'b1;
      @(negedge clk);
      ev = rx_event; rx_valid = '0;
   endtask

   task automatic t_reset();
      logic [15:0] rd; logic er;
      for (int c = 0; c < NUM_CH; c++) begin
         acc(ADDR_W'(c*16 + 0), 0, 1, 0, rd, er); chk("R1 ctl", {er, rd}, 0);
         acc(ADDR_W'(c*16 + 4), 0, 0, 0, rd, er); chk("R1 imode", {er, rd}, 0);
         acc(ADDR_W'(c*16 + 8), 0, 0, 0, rd, er); chk("R1 txb", {er, rd}, 0);
         acc(ADDR_W'(c*16 + 9), 0, 0, 0, rd, er); chk("R1 rxb", {er, rd}, 0);
         acc(ADDR_W'(c*16 + 12), 0, 0, 0, rd, er); chk("R1 stat", {er, rd}, 0);
      end
      acc(6'h2D, 0, 0, 0, rd, er); chk("R1 timer", {er, rd}, 0);
      chk("R1 strobes", {tx_send, rx_event}, 0);
   endtask

   task automatic t_ctl();
      logic [15:0] rd; logic er;
      acc(6'h00, 1, 1, 16'hBEEF, rd, er); chk("R3 ch0 write", {er, rd}, 0);
      acc(6'h00, 0, 1, 0, rd, er);        chk("R11 ch0 ctl half read", {er, rd}, 17'h0BEEF);
      acc(6'h00, 0, 0, 0, rd, er);        chk("R3 byte read refused", {er, rd}, 17'h10000);
      acc(6'h00, 1, 0, 16'h0011, rd, er); chk("R3 byte write refused", er, 1);
      acc(6'h00, 0, 1, 0, rd, er);        chk("R10 ctl unchanged", rd, 16'hBEEF);
      acc(6'h10, 1, 1, 16'h0C04, rd, er); chk("R3 ch1 mask bits ok", er, 0);
      acc(6'h10, 0, 1, 0, rd, er);        chk("R3 ch1 readback", rd, 16'h0C04);
      acc(6'h20, 1, 1, 16'h1230, rd, er); chk("R3 ch2 legal write", er, 0);
      acc(6'h20, 1, 1, 16'h0400, rd, er); chk("R3 ch2 ro bit refused", er, 1);
      acc(6'h20, 0, 1, 0, rd, er);        chk("R10 ch2 ctl unchanged", rd, 16'h1230);
   endtask

   task automatic t_imode();
      logic [15:0] rd; logic er;
      acc(6'h04, 1, 0, 16'h0035, rd, er); chk("R4 ch0 legal", er, 0);
      acc(6'h04, 1, 0, 16'h0002, rd, er); chk("R4 ch0 0x02 refused", er, 1);
      acc(6'h04, 0, 0, 0, rd, er);        chk("R4 ch0 readback", {er, rd}, 17'h00035);
      acc(6'h14, 1, 0, 16'h0080, rd, er); chk("R4 ch1 0x80 ok", er, 0);
      acc(6'h24, 1, 0, 16'h0080, rd, er); chk("R4 ch2 0x80 refused", er, 1);
      acc(6'h24, 1, 0, 16'h0031, rd, er); chk("R4 ch2 legal", er, 0);
      acc(6'h24, 0, 0, 0, rd, er);        chk("R4 ch2 readback", rd, 16'h0031);
      acc(6'h04, 0, 1, 0, rd, er);        chk("R4 half refused", {er, rd}, 17'h10000);
   endtask

   task automatic t_tx();
      logic [15:0] rd; logic er;
      acc(6'h18, 1, 0, 16'h005A, rd, er);
      chk("R8 send strobe", tx_send, 3'b010);
      chk("R8 tx lane", tx_byte, 24'h005A00);
      chk("R11 write gives zero", rd, 0);
      @(negedge clk);
      chk("R8 send one cycle", tx_send, 0);
      acc(6'h18, 0, 0, 0, rd, er); chk("R8 readback", {er, rd}, 17'h0005A);
      acc(6'h08, 1, 1, 16'h0077, rd, er);
      chk("R10 half txb refused", {er, tx_send}, 4'b1000);
      chk("R10 tx lane unchanged", tx_byte, 24'h005A00);
   endtask

   task automatic t_rx();
      logic [15:0] rd; logic er; logic [NUM_CH-1:0] ev;
      push(2, 8'hA7, ev); chk("R5 event", ev, 3'b100);
      @(negedge clk); chk("R5 event one cycle", rx_event, 0);
      acc(6'h2C, 0, 0, 0, rd, er); chk("R5 ready set", {er, rd}, 17'h00010);
      acc(6'h29, 0, 0, 0, rd, er); chk("R6 rxb read", rd, 16'h00A7);
      acc(6'h2C, 0, 0, 0, rd, er); chk("R6 ready cleared", rd, 0);
      push(0, 8'h11, ev);
      push(0, 8'h22, ev);
      acc(6'h0C, 0, 1, 0, rd, er); chk("R7 ch0 half status", {er, rd}, 17'h00010);
      acc(6'h09, 0, 0, 0, rd, er); chk("R6 overwrite", rd, 16'h0022);
      push(0, 8'h33, ev);
      rx_byte[7:0] = 8'h44; rx_valid[0] = 1'b1;
      acc(6'h09, 0, 0, 0, rd, er);
      rx_valid = '0;
      chk("R6 collision old byte", rd, 16'h0033);
      acc(6'h0C, 0, 0, 0, rd, er); chk("R6 collision ready kept", rd, 16'h0010);
      acc(6'h09, 0, 0, 0, rd, er); chk("R6 collision new byte", rd, 16'h0044);
   endtask

   task automatic t_status();
      logic [15:0] rd; logic er; logic [NUM_CH-1:0] ev;
      push(2, 8'h5E, ev);
      acc(6'h2C, 0, 1, 0, rd, er); chk("R7 ch2 half refused", {er, rd}, 17'h10000);
      acc(6'h2C, 1, 0, 16'h0000, rd, er); chk("R7 status write refused", er, 1);
      acc(6'h29, 1, 0, 16'h0099, rd, er); chk("R7 rxb write refused", er, 1);
      acc(6'h2C, 0, 0, 0, rd, er); chk("R10 ready untouched", rd, 16'h0010);
      acc(6'h29, 0, 0, 0, rd, er); chk("R10 rxb untouched", rd, 16'h005E);
   endtask

   task automatic t_timer();
      logic [15:0] rd; logic er;
      acc(6'h2D, 1, 0, 16'h009C, rd, er); chk("R9 write", er, 0);
      acc(6'h2D, 0, 0, 0, rd, er);        chk("R9 readback", {er, rd}, 17'h0009C);
      acc(6'h2D, 1, 1, 16'h0001, rd, er); chk("R9 half refused", er, 1);
      acc(6'h2D, 0, 0, 0, rd, er);        chk("R9 unchanged", rd, 16'h009C);
      acc(6'h0D, 0, 0, 0, rd, er);        chk("R9 ch0 has no timer", {er, rd}, 17'h10000);
   endtask

   task automatic t_unmapped();
      logic [15:0] rd; logic er;
      acc(6'h30, 0, 0, 0, rd, er); chk("R2 channel 3 refused", {er, rd}, 17'h10000);
      acc(6'h02, 0, 0, 0, rd, er); chk("R2 offset 2 refused", {er, rd}, 17'h10000);
      acc(6'h1A, 1, 0, 16'h00FF, rd, er); chk("R2 offset A refused", er, 1);
      @(negedge clk); chk("R10 err one cycle", bus_err, 0);
      acc(6'h14, 0, 0, 0, rd, er); chk("R2 ch1 imode map", {er, rd}, 17'h00080);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctl();
      t_imode();
      t_tx();
      t_rx();
      t_status();
      t_timer();
      t_unmapped();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule